// File: doc/BRIEF.md
# Single-Descriptor DMA Fetch Engine

This block moves one data buffer between word-wide system memory and a byte stream that leads to or from a flash interface. The command sequencer starts it with a direction (send or receive). The block fetches a four-word descriptor at the base address that its parent holds. It checks that software has handed the descriptor over, reads the byte count and the buffer address, moves the payload, and then gives the descriptor back by rewriting its status word.

The descriptor is four 32-bit words at consecutive addresses: control/status, length, buffer address, and a spare buffer address that is never used. In the status word, bit 31 marks that the engine owns the descriptor, bit 3 marks a first segment and bit 2 marks a last segment. Only a descriptor that is owned and is both first and last is processed. The length field is the low 12 bits of the length word. The engine rounds it up to the data-bus width (8 bytes by default).

The outcome is reported as sticky bits in an interrupt status vector. Bit 6 means a send finished, bit 7 means a receive finished, and bit 8 means no usable descriptor was found. Software clears these bits by writing ones to them.

Top module: `dmad_engine`

## Requirements
- R1: While in reset, and in the first cycle after it, `busy`, `irq_status`, `mem_req`, `tx_valid` and `rx_ready` are all zero. While idle, the block raises no memory request and no stream handshake.
- R2: A `start` pulse while idle begins a run. The run reads the status word at `desc_base`, then the length word at `desc_base+4`, then the buffer address at `desc_base+8`. The word at `desc_base+12` is never read. Each memory request holds `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`.
- R3: If status bit 31 is clear, the run ends with no payload movement and no write-back, and `irq_status` bit 8 is set.
- R4: If status bit 3 or bit 2 is clear, the descriptor is treated as unusable in the same way as R3 (bit 8, no payload, no write-back).
- R5: The payload byte count is bits [11:0] of the length word, rounded up to a multiple of BUS_BYTES (8). Higher bits of the length word are ignored.
- R6: With `start_rx`=0 (send), the block reads words from the buffer address upward. It puts exactly the byte count onto `tx_data`, lowest byte of each word first. `tx_data` is held while `tx_valid` is high and `tx_ready` is low.
- R7: With `start_rx`=1 (receive), the block accepts exactly the byte count from the receive stream. It packs the bytes lowest-first into words and writes them from the buffer address upward.
- R8: After the payload, the block writes the status word back to `desc_base` with bit 31 cleared and every other bit unchanged.
- R9: When the write-back is acknowledged, `irq_status` bit 6 (send) or bit 7 (receive) is set in the same cycle that `busy` falls.
- R10: `irq_status` bits stay set until cleared by a one in the same bit of `irq_clr`. Clearing one bit leaves the other bits as they are.
- R11: A `start` pulse while `busy` is high is ignored. The run in progress keeps its direction and no second run follows.
- R12: A byte count of zero moves no payload, but still performs the write-back and raises the completion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_base | input | AW | Descriptor base address, held by the parent |
| start | input | 1 | One-cycle request for a data phase |
| start_rx | input | 1 | Direction with `start`: 1 receive, 0 send |
| busy | output | 1 | A run is in progress |
| irq_clr | input | IRQ_W | Write-one-to-clear mask for `irq_status` |
| irq_status | output | IRQ_W | Sticky events: bit 6 send done, bit 7 receive done, bit 8 no descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | DW | Read data |
| tx_valid | output | 1 | Send byte valid |
| tx_data | output | 8 | Send byte |
| tx_ready | input | 1 | Sink accepts send byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block accepts receive byte |

## Verification
The assertions assume that the memory side answers every request with exactly one `mem_ack`, and only while the request is raised. They also assume that `desc_base` is held steady for the length of a run and that no payload buffer overlaps the descriptor. The bench memory model acknowledges one cycle after each request and then waits for the next one. The descriptor sits at a fixed base that never meets the send buffer or the receive buffer. Backpressure from both streams comes from a free-running counter, so that holding behaviour is exercised without breaking the one-ack-per-request rule.

// File: rtl/dmad_pkg.sv
// dmad_pkg: shared constants and state type for the descriptor DMA engine.
// Assumes 32-bit descriptor words; bit positions are fixed by the layout.
package dmad_pkg;
    localparam int OWN_BIT     = 31;
    localparam int FIRST_BIT   = 3;
    localparam int LAST_BIT    = 2;
    localparam int LEN_W       = 12;
    localparam int OFS_LEN     = 4;
    localparam int OFS_PTR     = 8;
    localparam int IRQ_TX_DONE = 6;
    localparam int IRQ_RX_DONE = 7;
    localparam int IRQ_NO_DESC = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STAT,
        ST_LEN,
        ST_PTR,
        ST_TXRD,
        ST_TXOUT,
        ST_RXIN,
        ST_RXWR,
        ST_WB
    } dmad_state_e;
endpackage

// File: rtl/dmad_irq_reg.sv
// dmad_irq_reg: sticky event bits with write-one-to-clear.
// Assumes set pulses last one cycle; a set wins over a clear in the same cycle.
module dmad_irq_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);
    // Hold events until software clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/dmad_len_round.sv
// dmad_len_round: rounds a byte count up to a multiple of the bus width.
// Assumes BUS_BYTES is a power of two and at least 2.
module dmad_len_round #(
    parameter int LEN_W     = 12,
    parameter int BUS_BYTES = 8
) (
    input  logic [LEN_W-1:0] raw,
    output logic [LEN_W:0]   rounded
);
    localparam int MW = $clog2(BUS_BYTES);

    logic [LEN_W:0] sum;

    // Add width-1 and drop the low bits.
    always_comb begin
        sum     = {1'b0, raw} + (LEN_W+1)'(BUS_BYTES - 1);
        rounded = {sum[LEN_W:MW], MW'(0)};
    end
endmodule

// File: rtl/dmad_byte_lane.sv
// dmad_byte_lane: one memory word seen as bytes, lowest byte first.
// Send side loads a word and steps through it; receive side fills it byte by byte.
// Assumes load, take and put are never asserted together.
module dmad_byte_lane #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          take,
    input  logic          put,
    input  logic [7:0]    put_byte,
    output logic [7:0]    cur_byte,
    output logic          at_last,
    output logic [DW-1:0] word_q
);
    localparam int NB = DW / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [IW-1:0] idx;
    logic [DW-1:0] word_nxt;

    // Steer the incoming byte into the lane selected by idx.
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign word_nxt[g*8 +: 8] = (put && idx == IW'(g)) ? put_byte : word_q[g*8 +: 8];
    end

    assign at_last = (idx == IW'(NB - 1));

    // Present the byte under the index.
    always_comb cur_byte = word_q[idx*8 +: 8];

    // Update the word buffer and the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx    <= '0;
        end else if (load) begin
            word_q <= load_word;
            idx    <= '0;
        end else if (put || take) begin
            word_q <= word_nxt;
            idx    <= at_last ? '0 : idx + IW'(1);
        end
    end
endmodule

// File: rtl/dmad_engine.sv
// dmad_engine: fetches one descriptor, moves its payload, returns ownership.
// Assumes DW is 32 (descriptor layout), one mem_ack per request, desc_base
// stable while busy, and BUS_BYTES a multiple of the word size in bytes.
module dmad_engine #(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int IRQ_W     = 16,
    parameter int BUS_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    desc_base,
    input  logic             start,
    input  logic             start_rx,
    output logic             busy,
    input  logic [IRQ_W-1:0] irq_clr,
    output logic [IRQ_W-1:0] irq_status,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready
);
    import dmad_pkg::*;

    localparam int CNT_W = LEN_W + 1;
    localparam int WBYTES = DW / 8;

    dmad_state_e      state;
    logic             dir_rx;
    logic [AW-1:0]    base_q;
    logic [DW-1:0]    stat_q;
    logic [AW-1:0]    ptr_q;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] len_rounded;
    logic             desc_ok;
    logic             lane_load, lane_take, lane_put, lane_last;
    logic [7:0]       lane_byte;
    logic [DW-1:0]    lane_word;
    logic [IRQ_W-1:0] irq_set;

    dmad_len_round #(.LEN_W(LEN_W), .BUS_BYTES(BUS_BYTES)) u_round (
        .raw     (mem_rdata[LEN_W-1:0]),
        .rounded (len_rounded)
    );

    dmad_byte_lane #(.DW(DW)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (lane_load),
        .load_word (mem_rdata),
        .take      (lane_take),
        .put       (lane_put),
        .put_byte  (rx_data),
        .cur_byte  (lane_byte),
        .at_last   (lane_last),
        .word_q    (lane_word)
    );

    dmad_irq_reg #(.W(IRQ_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (irq_set),
        .clr_vec (irq_clr),
        .status  (irq_status)
    );

    // Descriptor is usable only when owned and both first and last.
    assign desc_ok = mem_rdata[OWN_BIT] & mem_rdata[FIRST_BIT] & mem_rdata[LAST_BIT];

    assign busy      = (state != ST_IDLE);
    assign tx_valid  = (state == ST_TXOUT);
    assign tx_data   = lane_byte;
    assign rx_ready  = (state == ST_RXIN);
    assign lane_load = (state == ST_TXRD) && mem_ack;
    assign lane_take = tx_valid && tx_ready;
    assign lane_put  = rx_ready && rx_valid;

    // Drive the memory request for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = base_q;
        mem_wdata = '0;
        case (state)
            ST_STAT: mem_req = 1'b1;
            ST_LEN:  begin mem_req = 1'b1; mem_addr = base_q + AW'(OFS_LEN); end
            ST_PTR:  begin mem_req = 1'b1; mem_addr = base_q + AW'(OFS_PTR); end
            ST_TXRD: begin mem_req = 1'b1; mem_addr = ptr_q; end
            ST_RXWR: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ptr_q; mem_wdata = lane_word; end
            ST_WB:   begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_q & ~(DW'(1) << OWN_BIT);
            end
            default: ;
        endcase
    end

    // Raise one event bit when a run ends.
    always_comb begin
        irq_set = '0;
        if (state == ST_STAT && mem_ack && !desc_ok) irq_set[IRQ_NO_DESC] = 1'b1;
        if (state == ST_WB && mem_ack) begin
            if (dir_rx) irq_set[IRQ_RX_DONE] = 1'b1;
            else        irq_set[IRQ_TX_DONE] = 1'b1;
        end
    end

    // Sequence descriptor fetch, payload movement and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            dir_rx <= 1'b0;
            base_q <= '0;
            stat_q <= '0;
            ptr_q  <= '0;
            remain <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    base_q <= desc_base;
                    dir_rx <= start_rx;
                    state  <= ST_STAT;
                end
                ST_STAT: if (mem_ack) begin
                    stat_q <= mem_rdata;
                    state  <= desc_ok ? ST_LEN : ST_IDLE;
                end
                ST_LEN: if (mem_ack) begin
                    remain <= len_rounded;
                    state  <= ST_PTR;
                end
                ST_PTR: if (mem_ack) begin
                    ptr_q <= AW'(mem_rdata);
                    if (remain == '0) state <= ST_WB;
                    else if (dir_rx)  state <= ST_RXIN;
                    else              state <= ST_TXRD;
                end
                ST_TXRD: if (mem_ack) state <= ST_TXOUT;
                ST_TXOUT: if (lane_take) begin
                    remain <= remain - CNT_W'(1);
                    if (remain == CNT_W'(1)) begin
                        state <= ST_WB;
                    end else if (lane_last) begin
                        ptr_q <= ptr_q + AW'(WBYTES);
                        state <= ST_TXRD;
                    end
                end
                ST_RXIN: if (lane_put) begin
                    remain <= remain - CNT_W'(1);
                    if (lane_last) state <= ST_RXWR;
                end
                ST_RXWR: if (mem_ack) begin
                    ptr_q <= ptr_q + AW'(WBYTES);
                    state <= (remain == '0) ? ST_WB : ST_RXIN;
                end
                ST_WB: if (mem_ack) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dmad_engine_chk.sv
// dmad_engine_chk: protocol and event checks for dmad_engine.
// Assumes one mem_ack per request, desc_base stable during a run and no
// payload buffer overlapping the descriptor.
module dmad_engine_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IRQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    desc_base,
    input logic             busy,
    input logic [IRQ_W-1:0] irq_status,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [DW-1:0]    mem_wdata,
    input logic             mem_ack,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             tx_ready,
    input logic             rx_ready
);
    import dmad_pkg::*;

    // R1: nothing moves while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid && !rx_ready));

    // R2: a pending request keeps its address, direction and data.
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R6: a stalled send byte is held.
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R8: any write to the descriptor slot hands ownership back.
    assert_wb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == desc_base) |-> !mem_wdata[OWN_BIT]);

    // R9: send-done appears as the run ends.
    assert_tx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_TX_DONE]) |-> (!busy && $past(busy)));

    // R9: receive-done appears as the run ends.
    assert_rx_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_RX_DONE]) |-> (!busy && $past(busy)));

    // R3: no-descriptor appears as the run ends.
    assert_no_desc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[IRQ_NO_DESC]) |-> (!busy && $past(busy)));
endmodule

bind dmad_engine dmad_engine_chk #(.AW(AW), .DW(DW), .IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/test_dmad_engine.sv
// test_dmad_engine: table-driven runs over the descriptor engine, then directed cases.
module test_dmad_engine;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IRQ_W = 16;
    localparam logic [31:0] BASE = 32'h20;

    typedef struct packed {
        logic        rx;
        logic [31:0] stat;
        logic [31:0] len;
        logic [31:0] ptr;
        logic [3:0]  irq;
        logic [15:0] nbytes;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h8000_000C, 32'd8,          32'h40, 4'd6, 16'd8},
        '{1'b1, 32'h8000_000C, 32'd16,         32'h80, 4'd7, 16'd16},
        '{1'b0, 32'h8000_001C, 32'h00AB_C005,  32'h40, 4'd6, 16'd8},
        '{1'b0, 32'h0000_000C, 32'd8,          32'h40, 4'd8, 16'd0},
        '{1'b1, 32'h8000_0008, 32'd8,          32'h80, 4'd8, 16'd0},
        '{1'b1, 32'h8000_000C, 32'd0,          32'h80, 4'd7, 16'd0},
        '{1'b1, 32'h8000_000C, 32'd13,         32'h80, 4'd7, 16'd16},
        '{1'b0, 32'h8000_000C, 32'd31,         32'h40, 4'd6, 16'd32}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, start_rx = 1'b0, busy;
    logic [IRQ_W-1:0] irq_clr = '0, irq_status;
    logic mem_req, mem_we, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata = '0;
    logic tx_valid, tx_ready, rx_valid, rx_ready;
    logic [7:0] tx_data, rx_data;

    logic [31:0] mem [64];
    logic tb_we = 1'b0;
    logic [5:0] tb_wa = '0;
    logic [31:0] tb_wd = '0;
    logic cap_clr = 1'b1;
    logic rx_en = 1'b0;
    logic [7:0] seed = '0;
    logic [31:0] tx_base = '0;
    logic [7:0] cyc = '0;
    logic first_seen = 1'b0;
    logic [31:0] first_addr = '0;
    int p1_reads = 0, tx_cnt = 0, tx_err = 0, rx_idx = 0;
    int checks = 0, failures = 0;

    always #4 clk = ~clk;

    dmad_engine #(.AW(AW), .DW(DW), .IRQ_W(IRQ_W), .BUS_BYTES(8)) i_dmad_engine (
        .clk(clk), .rst_n(rst_n), .desc_base(BASE), .start(start), .start_rx(start_rx),
        .busy(busy), .irq_clr(irq_clr), .irq_status(irq_status),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return 8'(a * 32'd7 + 32'd3);
    endfunction

    function automatic logic [7:0] rbyte(input int k, input logic [7:0] s);
        return 8'(k * 13 + 1) + s;
    endfunction

    assign tx_ready = (cyc[2:0] != 3'd5);
    assign rx_valid = rx_en && (cyc[1:0] != 2'd2);
    assign rx_data  = rbyte(rx_idx, seed);

    // Memory model with one-cycle acknowledge, plus stream capture.
    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (tb_we) mem[tb_wa] <= tb_wd;
        else if (mem_req && mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        mem_ack   <= mem_req && !mem_ack;
        mem_rdata <= mem[mem_addr[7:2]];
        if (cap_clr) begin
            p1_reads <= 0; tx_cnt <= 0; tx_err <= 0; rx_idx <= 0; first_seen <= 1'b0;
        end else begin
            if (mem_req && !mem_ack && !first_seen) begin
                first_seen <= 1'b1;
                first_addr <= mem_addr;
            end
            if (mem_req && !mem_ack && !mem_we && mem_addr == BASE + 32'd12) p1_reads <= p1_reads + 1;
            if (tx_valid && tx_ready) begin
                if (tx_data != mbyte(tx_base + 32'(tx_cnt))) tx_err <= tx_err + 1;
                tx_cnt <= tx_cnt + 1;
            end
            if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = byte_addr[7:2]; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [7:0] peek_byte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[7:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    task automatic load_vec(input vec_t v, input int n);
        poke(BASE,          v.stat);
        poke(BASE + 32'd4,  v.len);
        poke(BASE + 32'd8,  v.ptr);
        poke(BASE + 32'd12, 32'hDEAD_BEEF);
        for (int w = 0; w < 16; w++) begin
            logic [31:0] a;
            a = v.ptr + 32'(4 * w);
            if (v.rx) poke(a, 32'h0);
            else      poke(a, {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)});
        end
        @(negedge clk);
        cap_clr = 1'b1; seed = 8'(n); tx_base = v.ptr; rx_en = 1'b1;
        @(negedge clk);
        cap_clr = 1'b0;
    endtask

    task automatic run(input logic rx, output bit done);
        int n;
        @(negedge clk);
        start = 1'b1; start_rx = rx;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        done = !busy;
    endtask

    task automatic clear_irq(input logic [IRQ_W-1:0] m);
        @(negedge clk);
        irq_clr = m;
        @(negedge clk);
        irq_clr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired before the run finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit done;
        repeat (3) @(negedge clk);
        // R1: reset state, during and just after reset
        chk("R1 busy in reset", busy, 0);
        chk("R1 irq in reset", irq_status, 0);
        chk("R1 req in reset", {mem_req, tx_valid, rx_ready}, 0);
        rst_n = 1'b1;
        cap_clr = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", {busy, mem_req, tx_valid, rx_ready}, 0);
        chk("R1 irq after reset", irq_status, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            load_vec(v, i);
            run(v.rx, done);
            chk("R9 run ends", done, 1);
            chk(v.irq == 4'd8 ? "R3 R4 unusable event" : "R9 done event",
                irq_status, longint'(1) << v.irq);
            chk("R2 status read first", first_addr, BASE);
            chk("R2 spare pointer unread", p1_reads, 0);
            if (v.irq == 4'd8) chk("R3 R4 no write-back", mem[BASE[7:2]], v.stat);
            else               chk("R8 write-back", mem[BASE[7:2]], {1'b0, v.stat[30:0]});
            if (v.rx) begin
                int bad;
                chk("R5 R7 R12 rx count", rx_idx, v.nbytes);
                bad = 0;
                for (int k = 0; k < int'(v.nbytes); k++)
                    if (peek_byte(v.ptr + 32'(k)) != rbyte(k, 8'(i))) bad++;
                chk("R7 rx data", bad, 0);
                chk("R5 R7 byte past end untouched", peek_byte(v.ptr + 32'(v.nbytes)), 0);
                chk("R7 tx quiet on rx", tx_cnt, 0);
            end else begin
                chk("R5 R6 tx count", tx_cnt, v.nbytes);
                chk("R6 tx data", tx_err, 0);
                chk("R6 rx quiet on tx", rx_idx, 0);
            end
            clear_irq('1);
            chk("R10 clear all", irq_status, 0);
        end

        // R11: second start during a send run is ignored
        load_vec(VECS[0], 20);
        @(negedge clk);
        start = 1'b1; start_rx = 1'b0;
        @(negedge clk);
        start_rx = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R11 single send run", tx_cnt, 8);
        chk("R11 no receive started", rx_idx, 0);
        chk("R11 only send event", irq_status, longint'(1) << 6);

        // R10: clearing one bit keeps the other
        load_vec(VECS[1], 21);
        run(1'b1, done);
        chk("R10 both events held", irq_status, (longint'(1) << 6) | (longint'(1) << 7));
        clear_irq(IRQ_W'(1) << 6);
        chk("R10 partial clear", irq_status, longint'(1) << 7);
        clear_irq('1);
        chk("R10 final clear", irq_status, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule